// File: doc/BRIEF.md
# Character Entry Controller for a Multiplexed Display

This block takes 6-bit character codes from a processor bus and files them into an eight-location character store. A multiplex scanner reads that store through its own read port. Each write is framed by two single-cycle pulses on the system clock. `wr_start` marks the opening edge of the write strobe, and `wr_end` marks the closing edge. The entry mode is sampled at the opening edge and held until the next opening edge. In random mode the opening edge also samples the target location from `wr_addr`. In sequential mode it samples the cascade enable `ser_en`. The character code itself is taken at the closing edge.

In sequential mode an internal pointer supplies the location. The first character goes to location 0, which is the leftmost character. Each accepted entry advances the pointer by one at the closing edge. After eight entries the controller reports that it is full. Further sequential entries are then dropped, so the next controller in a daisy-chain can take them. An active-low clear acts at once, without waiting for the clock, whenever the held mode is sequential. It blanks every location and rewinds the pointer. While an accepted write is open, `wr_busy` is raised so that the scanner can blank its outputs.

The write path has no back-pressure: every strobe is taken in the cycle it arrives, and the writer is never stalled. `wr_end` with no open write is dropped. If `wr_start` and `wr_end` arrive in the same cycle, the opening edge wins.

Top module: `disp_entry_ctrl`

## Requirements
- R1: After `rst_n` is released, every location reads the blank code 6'b100000, the pointer is at location 0, the held mode is sequential, `wr_busy` is 0 and `disp_full` is 0.
- R2: In random mode (`mode_seq`=0 at `wr_start`), the location is the value of `wr_addr` sampled with `wr_start`, and `wr_addr` changes after that have no effect. The code on `wr_data` sampled with `wr_end` is stored there and can be read one cycle later.
- R3: The entry mode is taken from `mode_seq` only in a cycle with `wr_start`. Changes of `mode_seq` at any other time do not alter where a write lands.
- R4: Accepted sequential entries land in locations 0, 1, 2 … in order. The pointer advances by one in the cycle of `wr_end`.
- R5: A sequential write whose `ser_en`, sampled with `wr_start`, is 0 changes no location, does not move the pointer and never raises `wr_busy`.
- R6: After eight accepted sequential entries, `disp_full` is 1. A sequential write that starts while the pointer is full changes nothing.
- R7: While the held mode is sequential, `clr_n`=0 at once blanks all locations to 6'b100000, rewinds the pointer, drops `disp_full` and cancels an open write. While the held mode is random, `clr_n` has no effect.
- R8: `disp_full` reflects the pointer only after the `wr_end` of a write that sampled sequential mode. It reads 0 from the `wr_end` of a write that sampled random mode.
- R9: `wr_busy` is 1 from the cycle after an accepted `wr_start` up to and including the cycle of the matching `wr_end`, and 0 otherwise.
- R10: `rd_data` shows the stored code at `rd_addr` combinationally, with no dependence on write activity.
- R11: A `wr_end` with no open write has no effect on the store, the pointer or `wr_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | One-cycle pulse: opening edge of the write strobe |
| wr_end | input | 1 | One-cycle pulse: closing edge of the write strobe |
| mode_seq | input | 1 | 1 = sequential entry, 0 = random entry; sampled with `wr_start` |
| wr_addr | input | 3 | Random-mode location; sampled with `wr_start` |
| ser_en | input | 1 | Sequential cascade enable; sampled with `wr_start` |
| wr_data | input | 6 | Character code; sampled with `wr_end` |
| clr_n | input | 1 | Asynchronous active-low clear; effective only in sequential mode |
| disp_full | output | 1 | Sequential pointer has taken eight entries |
| wr_busy | output | 1 | An accepted write is open |
| rd_addr | input | 3 | Scanner read location |
| rd_data | output | 6 | Stored code at `rd_addr` |

## Verification
Faults in this block show up only at the read port, `wr_busy` and `disp_full`. A pointer that is off by one puts a character one location to the side. That is seen on the first scanner read of either neighbour after the entry closes. A wrong acceptance decision shows at once: `wr_busy` disagrees one cycle after the opening edge. A lost full state shows either as a ninth character that overwrites a location or as a missing `disp_full` bit. A reference model therefore compares all three outputs on every cycle, while the read address sweeps the store, so a divergence shows within at most eight cycles.

// File: rtl/disp_entry_pkg.sv
package disp_entry_pkg;
  localparam int unsigned CHAR_W = 6;
  localparam int unsigned DEPTH  = 8;
  localparam int unsigned AW     = $clog2(DEPTH);
  localparam int unsigned CNT_W  = AW + 1;

  typedef logic [CHAR_W-1:0] char_t;
  typedef logic [AW-1:0]     loc_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  localparam char_t BLANK_CODE = char_t'(6'b100000);

  typedef enum logic {
    ENTRY_RANDOM = 1'b0,
    ENTRY_SEQ    = 1'b1
  } entry_mode_e;
endpackage

// File: rtl/entry_capture.sv
module entry_capture
  import disp_entry_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        arst_n,
  input  logic        wr_start,
  input  logic        wr_end,
  input  logic        mode_in,
  input  loc_t        addr_in,
  input  logic        ser_en,
  input  logic        full,
  output entry_mode_e mode_q,
  output entry_mode_e shown_mode_q,
  output loc_t        addr_q,
  output logic        open_q,
  output logic        acc_q,
  output logic        commit
);
  logic accept_now;

  assign accept_now = (mode_in == 1'b1) ? (ser_en && !full) : 1'b1;
  assign commit     = wr_end && !wr_start && open_q;

  // mode state lives outside the clear domain: it decides whether clear is live
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= ENTRY_SEQ;
      shown_mode_q <= ENTRY_SEQ;
    end else begin
      if (wr_start) mode_q <= entry_mode_e'(mode_in);
      if (commit)   shown_mode_q <= mode_q;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      addr_q <= '0;
      open_q <= 1'b0;
      acc_q  <= 1'b0;
    end else if (wr_start) begin
      addr_q <= addr_in;
      open_q <= 1'b1;
      acc_q  <= accept_now;
    end else if (commit) begin
      open_q <= 1'b0;
      acc_q  <= 1'b0;
    end
  end

  // R9
  busy_needs_open_chk: assert property (@(posedge clk) disable iff (!arst_n)
    acc_q |-> open_q);

  // R11
  stray_end_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (wr_end && !wr_start && !open_q) |=> !acc_q);
endmodule

// File: rtl/seq_pointer.sv
module seq_pointer
  import disp_entry_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  input  logic inc,
  output loc_t ptr,
  output logic full
);
  cnt_t cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                       cnt <= '0;
    else if (inc && cnt < cnt_t'(DEPTH)) cnt <= cnt + cnt_t'(1);
  end

  assign ptr  = cnt[AW-1:0];
  assign full = (cnt == cnt_t'(DEPTH));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!arst_n)
    cnt <= cnt_t'(DEPTH));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (inc && !full) |=> cnt == $past(cnt) + cnt_t'(1));

  // R6
  full_holds_chk: assert property (@(posedge clk) disable iff (!arst_n)
    full |=> full);
endmodule

// File: rtl/char_store.sv
module char_store
  import disp_entry_pkg::*;
(
  input  logic  clk,
  input  logic  arst_n,
  input  logic  we,
  input  loc_t  waddr,
  input  char_t wdata,
  input  loc_t  raddr,
  output char_t rdata
);
  char_t mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_loc
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                         mem[g] <= BLANK_CODE;
      else if (we && waddr == loc_t'(g))   mem[g] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!arst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/disp_entry_ctrl.sv
module disp_entry_ctrl
  import disp_entry_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_start,
  input  logic                  wr_end,
  input  logic                  mode_seq,
  input  logic [AW-1:0]         wr_addr,
  input  logic                  ser_en,
  input  logic [CHAR_W-1:0]     wr_data,
  input  logic                  clr_n,
  output logic                  disp_full,
  output logic                  wr_busy,
  input  logic [AW-1:0]         rd_addr,
  output logic [CHAR_W-1:0]     rd_data
);
  entry_mode_e mode_q, shown_mode_q;
  loc_t        addr_q, ptr;
  logic        open_q, acc_q, commit, full, arst_n, we, seq_inc;
  loc_t        waddr;

  // clear only acts while the held mode is sequential
  assign arst_n = rst_n && (clr_n || mode_q == ENTRY_RANDOM);

  entry_capture u_cap (
    .clk(clk), .rst_n(rst_n), .arst_n(arst_n),
    .wr_start(wr_start), .wr_end(wr_end), .mode_in(mode_seq),
    .addr_in(wr_addr), .ser_en(ser_en), .full(full),
    .mode_q(mode_q), .shown_mode_q(shown_mode_q), .addr_q(addr_q),
    .open_q(open_q), .acc_q(acc_q), .commit(commit)
  );

  assign we      = commit && acc_q;
  assign seq_inc = we && mode_q == ENTRY_SEQ;
  assign waddr   = (mode_q == ENTRY_SEQ) ? ptr : addr_q;

  seq_pointer u_ptr (
    .clk(clk), .arst_n(arst_n), .inc(seq_inc), .ptr(ptr), .full(full)
  );

  char_store u_mem (
    .clk(clk), .arst_n(arst_n), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assign disp_full = (shown_mode_q == ENTRY_SEQ) && full;
  assign wr_busy   = acc_q;

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(wr_busy) |-> $past(wr_start));

  // R5
  sen_block_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (wr_start && mode_seq && !ser_en) |=> !wr_busy);

  // R6
  full_block_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (wr_start && mode_seq && full) |=> !wr_busy);

  // R8
  full_shown_chk: assert property (@(posedge clk) disable iff (!arst_n)
    disp_full |-> full);
endmodule

// File: tb/disp_entry_ctrl_tb.sv
module disp_entry_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       wr_start = 0, wr_end = 0, mode_seq = 1, ser_en = 1, clr_n = 1;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [5:0] wr_data = 0, rd_data;
  logic       disp_full, wr_busy;

  int total = 0, bad = 0;

  // reference model state
  int  m_mem [8];
  int  m_cnt = 0;
  bit  m_mode = 1, m_shown = 1, m_open = 0, m_acc = 0;
  int  m_addr = 0;
  bit  checking = 0;

  disp_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_end(wr_end),
    .mode_seq(mode_seq), .wr_addr(wr_addr), .ser_en(ser_en), .wr_data(wr_data),
    .clr_n(clr_n), .disp_full(disp_full), .wr_busy(wr_busy),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  // model step on each clock edge
  always @(posedge clk) begin
    if (rst_n && (clr_n || !m_mode)) begin
      if (wr_start) begin
        m_mode = mode_seq; m_open = 1; m_addr = wr_addr;
        m_acc  = mode_seq ? (ser_en && m_cnt < 8) : 1;
      end else if (wr_end && m_open) begin
        m_shown = m_mode;
        if (m_acc) begin
          m_mem[m_mode ? m_cnt : m_addr] = wr_data;
          if (m_mode) m_cnt++;
        end
        m_open = 0; m_acc = 0;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (checking) begin
      chk(rd_data == m_mem[rd_addr], "R10 rd_data", rd_data, m_mem[rd_addr]);
      chk(wr_busy == m_acc, "R9 wr_busy", wr_busy, m_acc);
      chk(disp_full == (m_shown && m_cnt == 8), "R8 disp_full", disp_full,
          m_shown && m_cnt == 8);
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      step();
      rd_addr = rd_addr + 3'd1;
    end
  endtask

  task automatic peek(input int a, input int exp, input string req);
    rd_addr = a[2:0]; #1;
    chk(rd_data == exp[5:0], req, rd_data, exp);
  endtask

  task automatic do_write(input bit md, input int a, input int d, input bit sen,
                          input int exp_busy, input string req);
    step();
    mode_seq = md; wr_addr = a[2:0]; ser_en = sen; wr_start = 1;
    step();
    wr_start = 0; wr_addr = ~wr_addr; mode_seq = ~md; ser_en = ~sen;
    chk(wr_busy == exp_busy[0], req, wr_busy, exp_busy);
    idle(2);
    wr_end = 1; wr_data = d[5:0];
    step();
    wr_end = 0; wr_data = 6'h3f;
  endtask

  task automatic do_clear();
    step();
    clr_n = 0; #1;
    if (m_mode) begin
      for (int i = 0; i < 8; i++) m_mem[i] = 32;
      m_cnt = 0; m_open = 0; m_acc = 0;
    end
    step();
    clr_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_mem[i] = 32;
    step(); step();
    rst_n = 1;
    step();
    checking = 1;
    // R1 reset state
    for (int i = 0; i < 8; i++) peek(i, 32, "R1 blank after reset");
    chk(disp_full == 0, "R1 disp_full", disp_full, 0);
    chk(wr_busy == 0, "R1 wr_busy", wr_busy, 0);

    // R4 sequential fill
    do_write(1, 6, 1, 1, 1, "R9 busy seq");
    do_write(1, 6, 2, 1, 1, "R9 busy seq");
    do_write(1, 6, 3, 1, 1, "R9 busy seq");
    step();
    peek(0, 1, "R4 loc0"); peek(1, 2, "R4 loc1"); peek(2, 3, "R4 loc2");

    // R5 serial enable low
    do_write(1, 0, 9, 0, 0, "R5 busy stays low");
    step();
    peek(3, 32, "R5 loc3 untouched");

    for (int k = 0; k < 5; k++) do_write(1, 0, 10 + k, 1, 1, "R9 busy seq");
    step();
    chk(disp_full == 1, "R6 full after eight", disp_full, 1);
    do_write(1, 0, 40, 1, 0, "R6 write rejected when full");
    step();
    for (int i = 0; i < 8; i++) peek(i, m_mem[i], "R6 store unchanged");
    peek(7, 14, "R4 loc7");

    // R7 clear in sequential mode
    do_clear();
    step();
    for (int i = 0; i < 8; i++) peek(i, 32, "R7 blanked");
    chk(disp_full == 0, "R7 full dropped", disp_full, 0);

    // R2 random write, address change ignored
    do_write(0, 5, 7, 1, 1, "R9 busy random");
    step();
    peek(5, 7, "R2 loc5");
    peek(2, 32, "R2 complement addr untouched");
    // R7 clear ignored in random mode
    do_clear();
    step();
    peek(5, 7, "R7 no clear in random");

    // R3 mode latched at start: seq write goes to pointer location 0
    do_write(1, 5, 21, 1, 1, "R3 seq busy");
    step();
    peek(0, 21, "R3 seq lands at pointer");
    peek(5, 7, "R3 random entry kept");
    for (int k = 0; k < 7; k++) do_write(1, 0, 22 + k, 1, 1, "R9 busy seq");
    step();
    chk(disp_full == 1, "R8 full in seq", disp_full, 1);

    // R8 full stays until random write closes
    step();
    mode_seq = 0; wr_addr = 3; wr_start = 1;
    step();
    wr_start = 0;
    chk(disp_full == 1, "R8 full during random open", disp_full, 1);
    wr_end = 1; wr_data = 50;
    step();
    wr_end = 0;
    chk(disp_full == 0, "R8 full hidden after random", disp_full, 0);
    peek(3, 50, "R2 loc3");

    // R11 stray end
    wr_end = 1; wr_data = 60; wr_addr = 1;
    step();
    wr_end = 0;
    step();
    chk(wr_busy == 0, "R11 busy", wr_busy, 0);
    for (int i = 0; i < 8; i++) peek(i, m_mem[i], "R11 store unchanged");

    idle(10);
    checking = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule